// File: doc/BRIEF.md
# Chunked I2C Command-Tag Stream Generator

This block turns a single I2C message request into the byte stream consumed by a tag-driven I2C master engine. A request names a target address (7-bit or 10-bit), a direction and a byte count. The block cuts the message into chunks no larger than a fixed maximum and gives each chunk a short command header. For a write, the chunk's payload bytes follow the header; they are pulled from a valid/ready byte input. The bytes are packed into 32-bit words and pushed into an output FIFO.

After each chunk the block stops and waits for a completion pulse from the bus engine before it sends the next chunk's header. When the request is accepted, the block also reports the total number of header bytes the message will use, so that the engine's transfer counters can be loaded. A request with zero length is refused with an error pulse, and nothing is sent.

Top module: `i2c_chunk_tagger`

## Requirements
- R1: A request with `req_len` equal to 0, made while idle, raises `req_err` for exactly one cycle. It does not raise `busy` and writes no word.
- R2: From the cycle after a request is accepted until the message ends, `tag_total` equals 2×N + 2 + T. N is ceil(len / CHUNK_MAX) and T is 1 for 10-bit addressing, otherwise 0. With 7-bit addressing this is 4 + 2×(N−1).
- R3: The first chunk's header opens with 0x81. Next comes the byte formed from ({addr,rd_flag}) bits 7:0. With 10-bit addressing, one more byte follows holding ({addr,rd_flag}) >> 8. Later chunks carry no start byte and no address bytes.
- R4: Each chunk has a direction opcode after the address bytes, or at the start of the header for later chunks. The opcode is 0x82 for a write chunk and 0x83 for the last write chunk. It is 0x85 for a read chunk and 0x87 for the last read chunk.
- R5: The opcode is followed by one length byte holding the chunk's byte count, which is min(remaining, CHUNK_MAX). A count equal to CHUNK_MAX is sent as 0x00.
- R6: In a write, the chunk's payload bytes follow its header in input order. In a read, only the header is sent and `pay_ready` stays low.
- R7: Bytes are packed into words least significant lane first. A chunk's final partial word has zero in its unused upper lanes. Every chunk starts in a fresh word.
- R8: `out_wr` is never high while `out_full` is high. A held word waits until the FIFO has room.
- R9: Once a chunk's last word has been written, no further word is written until `chunk_done` pulses.
- R10: `busy` rises the cycle after a valid request is accepted. It falls in the cycle after the `chunk_done` that ends the last chunk, and in that same cycle `done` is high for exactly one cycle. Requests made while busy are ignored.
- R11: After reset, `busy`, `done`, `req_err`, `out_wr` and `pay_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | 10 | Target address |
| req_read | input | 1 | 1 for a read message, 0 for a write |
| req_ten | input | 1 | Selects 10-bit addressing |
| req_len | input | LEN_W | Message byte count |
| req_err | output | 1 | One-cycle pulse: zero-length request refused |
| tag_total | output | LEN_W+2 | Header byte total of the accepted message |
| pay_data | input | 8 | Write payload byte |
| pay_valid | input | 1 | Payload byte available |
| pay_ready | output | 1 | Payload byte taken this cycle when valid |
| out_word | output | WORD_W | Packed word to the output FIFO |
| out_wr | output | 1 | FIFO write strobe |
| out_full | input | 1 | FIFO full |
| chunk_done | input | 1 | Bus engine finished the current chunk |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle pulse at end of message |

## Verification
The bench builds the block with CHUNK_MAX = 4 and LEN_W = 8, so a nine-byte message already spans three chunks. At these settings the length-byte wrap to 0x00 occurs at four bytes, instead of at the default size of 256 bytes. Messages of one to nine bytes exercise chunk boundaries, partial words and 10-bit headers that straddle word lanes, while keeping the expected word lists short. Periodic FIFO-full and payload gaps stress the holding word and the handshake.

// File: rtl/i2c_tag_pkg.sv
package i2c_tag_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_FLUSH,
    ST_WAIT
  } tag_state_t;

  localparam logic [7:0] OP_START   = 8'h81;
  localparam logic [7:0] OP_WR      = 8'h82;
  localparam logic [7:0] OP_WR_STOP = 8'h83;
  localparam logic [7:0] OP_RD      = 8'h85;
  localparam logic [7:0] OP_RD_STOP = 8'h87;

endpackage

// File: rtl/i2c_tag_plan.sv
module i2c_tag_plan #(
  parameter int LEN_W     = 16,
  parameter int CHUNK_MAX = 256
) (
  input  logic [LEN_W-1:0] len,
  input  logic             ten,
  output logic [LEN_W+1:0] tag_total
);
  localparam int SUM_W = LEN_W + 1;
  localparam int TT_W  = LEN_W + 2;

  logic [SUM_W-1:0] rounded;
  logic [SUM_W-1:0] n_chunks;

  always_comb begin
    rounded   = {1'b0, len} + SUM_W'(CHUNK_MAX - 1);
    n_chunks  = rounded / SUM_W'(CHUNK_MAX);
    // first chunk: start + addr + opcode + length; later chunks: opcode + length
    tag_total = TT_W'({n_chunks, 1'b0}) + TT_W'(2) + TT_W'(ten);
  end
endmodule

// File: rtl/i2c_tag_header.sv
module i2c_tag_header
  import i2c_tag_pkg::*;
(
  input  logic       first,
  input  logic       ten,
  input  logic       rd,
  input  logic       last,
  input  logic [9:0] addr,
  input  logic [7:0] len_code,
  input  logic [2:0] idx,
  output logic [7:0] hdr_byte,
  output logic [2:0] hdr_len
);
  logic [15:0] addr_word;
  logic [2:0]  slot;
  logic [7:0]  op;

  always_comb begin
    addr_word = {5'd0, addr, rd};
    if (rd) op = last ? OP_RD_STOP : OP_RD;
    else    op = last ? OP_WR_STOP : OP_WR;

    if (first) hdr_len = ten ? 3'd5 : 3'd4;
    else       hdr_len = 3'd2;

    // logical slots: 0 start, 1 addr low, 2 addr high, 3 opcode, 4 length
    if (first) slot = (ten || idx < 3'd2) ? idx : idx + 3'd1;
    else       slot = idx + 3'd3;

    case (slot)
      3'd0:    hdr_byte = OP_START;
      3'd1:    hdr_byte = addr_word[7:0];
      3'd2:    hdr_byte = addr_word[15:8];
      3'd3:    hdr_byte = op;
      default: hdr_byte = len_code;
    endcase
  end
endmodule

// File: rtl/i2c_word_packer.sv
module i2c_word_packer #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        in_byte,
  input  logic              in_valid,
  output logic              in_accept,
  input  logic              flush,
  output logic [WORD_W-1:0] out_word,
  output logic              out_wr,
  input  logic              out_full,
  output logic              empty
);
  localparam int LANES = WORD_W / 8;
  localparam int LW    = $clog2(LANES + 1);

  logic [WORD_W-1:0] acc;
  logic [LW-1:0]     fill;
  logic              pend;

  assign in_accept = !pend;
  assign empty     = (fill == '0) && !pend;
  assign out_wr    = pend && !out_full;
  assign out_word  = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      fill <= '0;
      pend <= 1'b0;
    end else if (pend) begin
      if (!out_full) begin
        pend <= 1'b0;
        acc  <= '0;
        fill <= '0;
      end
    end else if (in_valid) begin
      for (int l = 0; l < LANES; l++) begin
        if (fill == LW'(l)) acc[l*8 +: 8] <= in_byte;
      end
      fill <= fill + LW'(1);
      if (fill == LW'(LANES - 1)) pend <= 1'b1;
    end else if (flush && fill != '0) begin
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_chunk_tagger.sv
module i2c_chunk_tagger
  import i2c_tag_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CHUNK_MAX = 256,
  parameter int WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [9:0]        req_addr,
  input  logic              req_read,
  input  logic              req_ten,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_err,
  output logic [LEN_W+1:0]  tag_total,
  input  logic [7:0]        pay_data,
  input  logic              pay_valid,
  output logic              pay_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_wr,
  input  logic              out_full,
  input  logic              chunk_done,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(CHUNK_MAX + 1);
  localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_MAX);
  localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK_MAX);

  tag_state_t       state;
  logic [9:0]       addr_q;
  logic             rd_q, ten_q, first_q;
  logic [LEN_W-1:0] remain;
  logic [2:0]       hdr_idx;
  logic [CNT_W-1:0] data_cnt;
  logic [LEN_W+1:0] plan_total;

  logic [CNT_W-1:0] chunk_len;
  logic             last_chunk;
  logic [7:0]       len_code, hdr_byte, pk_byte;
  logic [2:0]       hdr_len;
  logic             pk_valid, pk_accept, pk_empty, pk_flush;

  always_comb begin
    last_chunk = (remain <= CHUNK_L);
    chunk_len  = last_chunk ? CNT_W'(remain) : CHUNK_C;
    len_code   = (chunk_len == CHUNK_C) ? 8'd0 : 8'(chunk_len);
    pk_valid   = (state == ST_HDR) || (state == ST_DATA && pay_valid);
    pk_byte    = (state == ST_HDR) ? hdr_byte : pay_data;
    pk_flush   = (state == ST_FLUSH);
    pay_ready  = (state == ST_DATA) && pk_accept;
  end

  i2c_tag_plan #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX)) plan_i (
    .len(req_len), .ten(req_ten), .tag_total(plan_total)
  );

  i2c_tag_header hdr_i (
    .first(first_q), .ten(ten_q), .rd(rd_q), .last(last_chunk),
    .addr(addr_q), .len_code(len_code), .idx(hdr_idx),
    .hdr_byte(hdr_byte), .hdr_len(hdr_len)
  );

  i2c_word_packer #(.WORD_W(WORD_W)) pack_i (
    .clk(clk), .rst(rst), .in_byte(pk_byte), .in_valid(pk_valid),
    .in_accept(pk_accept), .flush(pk_flush), .out_word(out_word),
    .out_wr(out_wr), .out_full(out_full), .empty(pk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      ten_q     <= 1'b0;
      first_q   <= 1'b0;
      remain    <= '0;
      hdr_idx   <= '0;
      data_cnt  <= '0;
      tag_total <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      req_err   <= 1'b0;
    end else begin
      done    <= 1'b0;
      req_err <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          if (req_len == '0) begin
            req_err <= 1'b1;
          end else begin
            addr_q    <= req_addr;
            rd_q      <= req_read;
            ten_q     <= req_ten;
            remain    <= req_len;
            first_q   <= 1'b1;
            hdr_idx   <= '0;
            tag_total <= plan_total;
            busy      <= 1'b1;
            state     <= ST_HDR;
          end
        end
        ST_HDR: if (pk_accept) begin
          hdr_idx <= hdr_idx + 3'd1;
          if (hdr_idx == hdr_len - 3'd1) begin
            if (rd_q) begin
              state <= ST_FLUSH;
            end else begin
              data_cnt <= chunk_len;
              state    <= ST_DATA;
            end
          end
        end
        ST_DATA: if (pay_valid && pk_accept) begin
          data_cnt <= data_cnt - CNT_W'(1);
          if (data_cnt == CNT_W'(1)) state <= ST_FLUSH;
        end
        ST_FLUSH: if (pk_empty) state <= ST_WAIT;
        ST_WAIT: if (chunk_done) begin
          remain  <= remain - LEN_W'(chunk_len);
          first_q <= 1'b0;
          hdr_idx <= '0;
          if (last_chunk) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_HDR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_chunk_tagger_chk.sv
module i2c_chunk_tagger_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [LEN_W-1:0] req_len,
  input logic             req_err,
  input logic             out_wr,
  input logic             out_full,
  input logic             pay_ready,
  input logic             busy,
  input logic             done
);
  // R8
  a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> !out_full);

  // R1
  a_r1_zero_len_refused: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_len == '0) |=> (req_err && !busy));

  a_r1_err_single: assert property (@(posedge clk) disable iff (rst)
    req_err |=> !req_err);

  // R10
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $fell(busy)));

  // R6
  a_r6_ready_only_busy: assert property (@(posedge clk) disable iff (rst)
    pay_ready |-> busy);
endmodule

bind i2c_chunk_tagger i2c_chunk_tagger_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
  .req_err(req_err), .out_wr(out_wr), .out_full(out_full),
  .pay_ready(pay_ready), .busy(busy), .done(done)
);

// File: tb/i2c_chunk_tagger_tb_top.sv
module i2c_chunk_tagger_tb_top;
  localparam int LEN_W  = 8;
  localparam int CHUNK  = 4;
  localparam int WORD_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [9:0] req_addr = '0;
  logic req_read = 1'b0, req_ten = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_err;
  logic [LEN_W+1:0] tag_total;
  logic [7:0] pay_data = '0;
  logic pay_valid = 1'b0, pay_ready;
  logic [WORD_W-1:0] out_word;
  logic out_wr, out_full = 1'b0;
  logic chunk_done = 1'b0;
  logic busy, done;

  i2c_chunk_tagger #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_read(req_read), .req_ten(req_ten), .req_len(req_len),
    .req_err(req_err), .tag_total(tag_total), .pay_data(pay_data),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .out_word(out_word),
    .out_wr(out_wr), .out_full(out_full), .chunk_done(chunk_done),
    .busy(busy), .done(done)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, pidx = 0, plen = 0, got = 0, full_viol = 0;
  bit hs_last = 1'b0, gaps = 1'b0, fullpat = 1'b0;
  logic [7:0]  parr  [64];
  logic [31:0] got_w [64];
  logic [31:0] exp_w [64];
  int cend [16];
  int nexp, nch;

  // fields: len[21:14] addr[13:4] rd[3] ten[2] fifo-full pattern[1] payload gaps[0]
  localparam logic [21:0] VEC [6] = '{
    {8'd3, 10'h02A, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'd4, 10'h051, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'd9, 10'h2C5, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'd5, 10'h017, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd8, 10'h3FF, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'd1, 10'h07F, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (hs_last) pidx++;
    out_full  = fullpat && (cyc % 3 == 0);
    pay_valid = (pidx < plen) && !(gaps && (cyc % 4 == 1));
    pay_data  = (pidx < 64) ? parr[pidx] : 8'h00;
    #1;
    hs_last = (pay_valid === 1'b1) && (pay_ready === 1'b1);
    if (out_wr === 1'b1) begin
      if (out_full) full_viol++;
      if (got < 64) got_w[got] = out_word;
      got++;
    end
  end

  task automatic build_expect(input int len, input logic [9:0] addr,
                              input bit rd, input bit ten);
    logic [15:0] aw;
    int rem, off, cl;
    logic [7:0] b [16];
    int nb;
    aw = {5'd0, addr, rd};
    rem = len; off = 0; nexp = 0; nch = 0;
    while (rem > 0) begin
      cl = (rem > CHUNK) ? CHUNK : rem;
      nb = 0;
      if (nch == 0) begin
        b[nb++] = 8'h81;
        b[nb++] = aw[7:0];
        if (ten) b[nb++] = aw[15:8];
      end
      if (rd) b[nb++] = (rem <= CHUNK) ? 8'h87 : 8'h85;
      else    b[nb++] = (rem <= CHUNK) ? 8'h83 : 8'h82;
      b[nb++] = (cl == CHUNK) ? 8'h00 : 8'(cl);
      if (!rd) for (int i = 0; i < cl; i++) b[nb++] = parr[off + i];
      for (int i = 0; i < nb; i += 4) begin
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < 4; k++) if (i + k < nb) w[k*8 +: 8] = b[i + k];
        exp_w[nexp++] = w;
      end
      cend[nch++] = nexp;
      off += cl;
      rem -= cl;
    end
  endtask

  task automatic run_msg(input int len, input logic [9:0] addr, input bit rd,
                         input bit ten, input bit fp, input bit gp);
    for (int i = 0; i < 64; i++) parr[i] = 8'h30 + 8'(i * 7) + 8'(len);
    build_expect(len, addr, rd, ten);
    @(negedge clk);
    pidx = 0; got = 0; fullpat = fp; gaps = gp;
    plen = rd ? 0 : len;
    req_addr = addr; req_read = rd; req_ten = ten; req_len = LEN_W'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    chk(busy == 1'b1, "R10", "busy after accept", 32'(busy), 32'd1);
    chk(tag_total == (LEN_W+2)'(2 * nch + 2 + (ten ? 1 : 0)), "R2", "tag total",
        32'(tag_total), 32'(2 * nch + 2 + (ten ? 1 : 0)));
    for (int c = 0; c < nch; c++) begin
      int w;
      w = 0;
      while (got < cend[c] && w < 3000) begin @(negedge clk); #2; w++; end
      for (int r = 0; r < 6; r++) begin
        @(negedge clk);
        // stray request while busy must be ignored (R10)
        if (c == 0 && r == 0) begin req_valid = 1'b1; req_len = LEN_W'(2); end
        else req_valid = 1'b0;
      end
      #2;
      chk(got == cend[c], "R9", "words before chunk_done", 32'(got), 32'(cend[c]));
      chk(busy == 1'b1, "R10", "busy mid message", 32'(busy), 32'd1);
      @(negedge clk); chunk_done = 1'b1;
      @(negedge clk); chunk_done = 1'b0; #2;
      if (c == nch - 1) begin
        chk(done == 1'b1, "R10", "done pulse", 32'(done), 32'd1);
        chk(busy == 1'b0, "R10", "busy cleared", 32'(busy), 32'd0);
        @(negedge clk); #2;
        chk(done == 1'b0, "R10", "done one cycle", 32'(done), 32'd0);
      end
    end
    chk(pidx == plen, "R6", "payload bytes consumed", 32'(pidx), 32'(plen));
    chk(got == nexp, "R6", "word count", 32'(got), 32'(nexp));
    for (int i = 0; i < nexp && i < got; i++)
      chk(got_w[i] == exp_w[i], "R3 R4 R5 R6 R7", $sformatf("word %0d", i),
          got_w[i], exp_w[i]);
    repeat (8) @(negedge clk);
    #2;
    chk(got == nexp && busy == 1'b0, "R10", "stray request ignored", 32'(got), 32'(nexp));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    // R11 reset state
    chk(busy == 1'b0, "R11", "busy", 32'(busy), 32'd0);
    chk(done == 1'b0, "R11", "done", 32'(done), 32'd0);
    chk(req_err == 1'b0, "R11", "req_err", 32'(req_err), 32'd0);
    chk(out_wr == 1'b0, "R11", "out_wr", 32'(out_wr), 32'd0);
    chk(pay_ready == 1'b0, "R11", "pay_ready", 32'(pay_ready), 32'd0);

    // R1 zero-length request
    @(negedge clk);
    got = 0; req_len = '0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; #2;
    chk(req_err == 1'b1, "R1", "error pulse", 32'(req_err), 32'd1);
    chk(busy == 1'b0, "R1", "no busy", 32'(busy), 32'd0);
    repeat (10) @(negedge clk);
    #2;
    chk(got == 0, "R1", "no words", 32'(got), 32'd0);
    chk(req_err == 1'b0, "R1", "error single cycle", 32'(req_err), 32'd0);

    for (int v = 0; v < 6; v++)
      run_msg(int'(VEC[v][21:14]), VEC[v][13:4], VEC[v][3], VEC[v][2],
              VEC[v][1], VEC[v][0]);

    chk(full_viol == 0, "R8", "writes while full", 32'(full_viol), 32'd0);
    finish_run();
  end
endmodule